// File: doc/BRIEF.md
# Square-Wave Timer Channel with Odd-Count Correction

This block is one channel of a 16-bit interval timer, fixed in its square-wave mode. On each enabled timer tick it lowers its counting element by two and toggles the output at every terminal count, so a programmed count N gives an output period of N ticks. An odd count cannot reach zero by steps of two. A correction flip-flop therefore chooses whether an odd value drops by one or by three. The flip-flop changes state at every reload, so an odd count gives a high phase one tick longer than the low phase.

Surrounding logic drives a single-cycle mode-set pulse to restart the channel and a load pulse that carries a 16-bit count. It also supplies a tick enable (one tick per cycle where it is high) and a gate level. The gate both holds the channel off and restarts it. The output level and the low 16 bits of the counting element are available continuously.

Top module: `sqwave_timer`

## Requirements
- R1: After reset, `wave_out` is 1 and `count_val` is 0, and ticks leave the count unchanged until a count has been loaded.
- R2: On a counting tick, an even counter value above 2 is lowered by exactly 2.
- R3: On a counting tick, an odd counter value is lowered by 1 when the correction flip-flop is 0 and by 3 when it is 1; the result is even. The flip-flop is 0 after reset, mode set and gate restart.
- R4: When the step would reach zero, the counter instead reloads from the count register, `wave_out` inverts and the correction flip-flop inverts.
- R5: With ticks on every cycle, an odd count N holds `wave_out` high for (N+1)/2 ticks and low for (N-1)/2 ticks; an even N gives N/2 ticks each.
- R6: A mode-set pulse makes `wave_out` 1 on the next cycle, clears the count register and halts counting; the first load after it puts the count into the counter on the next tick.
- R7: While `gate_in` is 0, `wave_out` is 1 from the next cycle on and ticks leave the count unchanged.
- R8: A 0-to-1 change of `gate_in` (with a count loaded) makes the next tick reload the counter from the count register, set `wave_out` to 1 and clear the correction flip-flop.
- R9: A load while counting is running only updates the count register; the counter keeps its sequence until the next terminal count or gate restart.
- R10: A loaded count of 0 stands for 65536: `count_val` reads 0 after the loading tick, 65534 one tick later, and the output holds each level for 32768 ticks without the counter exceeding 65536.
- R11: In a cycle where `tick_en` is 0, the counter value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable, one tick per high cycle |
| gate_in | input | 1 | Gate level; low holds the channel, a rise restarts it |
| mode_set | input | 1 | Single-cycle pulse restarting the channel configuration |
| load_req | input | 1 | Single-cycle pulse writing `load_val` to the count register |
| load_val | input | 16 | Count to write; 0 means 65536 |
| wave_out | output | 1 | Square-wave output |
| count_val | output | 16 | Low 16 bits of the counting element |

## Verification
A wrong correction flip-flop shows at `count_val` on the first odd step after a reload. A drop of 1 instead of 3, or the reverse, is visible one tick later. It also skews the measured high and low phase lengths by one tick within a single period. A stuck output register or a missed terminal count shows as a phase that never ends or has the wrong length within N ticks of the load. A count register applied too early or too late after a running load appears at the reload that follows. An overflow in the 65536 case appears as a wrong `count_val` on the second tick after the load.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    STEP_TWO   = 2'd0,
    STEP_ONE   = 2'd1,
    STEP_THREE = 2'd2
  } step_kind_t;

endpackage

// File: rtl/sqw_gate_edge.sv
module sqw_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate_in;
  end

  assign gate_rise = gate_in & ~gate_q;

endmodule

// File: rtl/sqw_step.sv
module sqw_step
  import sqw_pkg::*;
#(
  parameter int EXT_W = 17
) (
  input  logic [EXT_W-1:0] ce_cur,
  input  logic             odd_ff,
  output logic [EXT_W-1:0] ce_next,
  output logic             term_hit
);

  step_kind_t       kind;
  logic [EXT_W-1:0] amount;

  always_comb begin
    if (!ce_cur[0])  kind = STEP_TWO;
    else if (odd_ff) kind = STEP_THREE;
    else             kind = STEP_ONE;

    case (kind)
      STEP_ONE:   amount = EXT_W'(1);
      STEP_THREE: amount = EXT_W'(3);
      default:    amount = EXT_W'(2);
    endcase

    term_hit = (ce_cur <= amount);
    ce_next  = term_hit ? '0 : (ce_cur - amount);
  end

endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             mode_set,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  output logic             wave_out,
  output logic [CNT_W-1:0] count_val
);

  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] FULL_CNT = EXT_W'(1) << CNT_W;

  logic [EXT_W-1:0] ce_q, ce_d;
  logic [CNT_W-1:0] cr_q, cr_d;
  logic             odd_q, odd_d;
  logic             out_q, out_d;
  logic             loaded_q, loaded_d;
  logic             first_q, first_d;
  logic             trig_q, trig_d;

  logic             gate_rise;
  logic [EXT_W-1:0] step_next;
  logic             step_term;
  logic [EXT_W-1:0] cr_ext;
  logic             running;

  sqw_gate_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_in  (gate_in),
    .gate_rise(gate_rise)
  );

  sqw_step #(.EXT_W(EXT_W)) u_step (
    .ce_cur  (ce_q),
    .odd_ff  (odd_q),
    .ce_next (step_next),
    .term_hit(step_term)
  );

  assign cr_ext  = (cr_q == '0) ? FULL_CNT : {1'b0, cr_q};
  assign running = loaded_q & ~first_q;

  always_comb begin
    ce_d     = ce_q;
    cr_d     = cr_q;
    odd_d    = odd_q;
    out_d    = out_q;
    loaded_d = loaded_q;
    first_d  = first_q;
    trig_d   = trig_q;

    if (mode_set) begin
      cr_d     = '0;
      odd_d    = 1'b0;
      out_d    = 1'b1;
      loaded_d = 1'b0;
      first_d  = 1'b0;
      trig_d   = 1'b0;
    end else begin
      if (!gate_in) begin
        out_d = 1'b1;
      end else if (tick_en) begin
        if (first_q || trig_q) begin
          ce_d    = cr_ext;
          odd_d   = 1'b0;
          out_d   = 1'b1;
          first_d = 1'b0;
          trig_d  = 1'b0;
        end else if (running) begin
          if (step_term) begin
            ce_d  = cr_ext;
            odd_d = ~odd_q;
            out_d = ~out_q;
          end else begin
            ce_d = step_next;
          end
        end
      end

      if (load_req) begin
        cr_d     = load_val;
        loaded_d = 1'b1;
        if (!loaded_q) first_d = 1'b1;
      end

      if (gate_rise && loaded_q) trig_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= '0;
      cr_q     <= '0;
      odd_q    <= 1'b0;
      out_q    <= 1'b1;
      loaded_q <= 1'b0;
      first_q  <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      ce_q     <= ce_d;
      cr_q     <= cr_d;
      odd_q    <= odd_d;
      out_q    <= out_d;
      loaded_q <= loaded_d;
      first_q  <= first_d;
      trig_q   <= trig_d;
    end
  end

  assign wave_out  = out_q;
  assign count_val = ce_q[CNT_W-1:0];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q <= FULL_CNT);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(ce_q));

  // R7
  gate_low_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_in |=> out_q);

  // R6
  mode_set_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (out_q && !loaded_q));

  // R2
  even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && gate_in && running && !trig_q && !mode_set && !ce_q[0] && ce_q > EXT_W'(2))
    |=> ce_q == $past(ce_q) - EXT_W'(2));

  // R3
  odd_to_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && gate_in && running && !trig_q && !mode_set && ce_q[0] && ce_q > EXT_W'(3))
    |=> !ce_q[0]);

  // R4
  term_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && gate_in && running && !trig_q && !mode_set && step_term)
    |=> (out_q != $past(out_q)) && (odd_q != $past(odd_q)));

endmodule

// File: tb/sqwave_timer_tb_top.sv
`timescale 1ns/1ps
module sqwave_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        gate_in;
  logic        mode_set;
  logic        load_req;
  logic [15:0] load_val;
  logic        wave_out;
  logic [15:0] count_val;

  int n_checks = 0;
  int n_fails  = 0;

  // each entry: {count N, expected high ticks, expected low ticks}
  localparam int NV = 6;
  localparam logic [NV-1:0][47:0] VEC = {
    {16'd2,  16'd1, 16'd1},
    {16'd3,  16'd2, 16'd1},
    {16'd4,  16'd2, 16'd2},
    {16'd5,  16'd3, 16'd2},
    {16'd7,  16'd4, 16'd3},
    {16'd10, 16'd5, 16'd5}
  };

  sqwave_timer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .gate_in  (gate_in),
    .mode_set (mode_set),
    .load_req (load_req),
    .load_val (load_val),
    .wave_out (wave_out),
    .count_val(count_val)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_mode();
    mode_set = 1'b1;
    @(negedge clk);
    mode_set = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] v);
    load_req = 1'b1;
    load_val = v;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  task automatic step_tick();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic measure_run(input int exp_hi, input int exp_lo, input string req);
    int lo_n = 0;
    int hi_n = 0;
    tick_en = 1'b1;
    while (wave_out !== 1'b0) @(negedge clk);
    while (wave_out === 1'b0) begin lo_n++; @(negedge clk); end
    while (wave_out === 1'b1) begin hi_n++; @(negedge clk); end
    tick_en = 1'b0;
    check(lo_n == exp_lo, req, lo_n, exp_lo);
    check(hi_n == exp_hi, req, hi_n, exp_hi);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; gate_in = 1'b1;
    mode_set = 1'b0; load_req = 1'b0; load_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, no counting without a load
    check(wave_out == 1'b1, "R1", wave_out, 1);
    check(count_val == 16'd0, "R1", count_val, 0);
    step_tick();
    check(count_val == 16'd0, "R1", count_val, 0);

    // R5: table of counts with measured phase lengths
    for (int i = 0; i < NV; i++) begin
      pulse_mode();
      do_load(VEC[i][47:32]);
      measure_run(int'(VEC[i][31:16]), int'(VEC[i][15:0]), "R5");
    end

    // R2/R3/R4/R6: stepped sequence for N = 7
    pulse_mode();
    do_load(16'd7);
    step_tick();
    check(count_val == 16'd7, "R6", count_val, 7);
    step_tick();
    check(count_val == 16'd6, "R3", count_val, 6);
    step_tick();
    check(count_val == 16'd4, "R2", count_val, 4);
    step_tick();
    check(count_val == 16'd2, "R2", count_val, 2);
    step_tick();
    check(count_val == 16'd7, "R4", count_val, 7);
    check(wave_out == 1'b0, "R4", wave_out, 0);
    step_tick();
    check(count_val == 16'd4, "R3", count_val, 4);
    step_tick();
    step_tick();
    check(count_val == 16'd7, "R4", count_val, 7);
    check(wave_out == 1'b1, "R4", wave_out, 1);

    // R9: load while running waits for the terminal count
    do_load(16'd3);
    step_tick();
    check(count_val == 16'd6, "R9", count_val, 6);
    step_tick();
    step_tick();
    step_tick();
    check(count_val == 16'd3, "R9", count_val, 3);
    check(wave_out == 1'b0, "R9", wave_out, 0);

    // R11: no tick, no change
    repeat (5) @(negedge clk);
    check(count_val == 16'd3, "R11", count_val, 3);
    check(wave_out == 1'b0, "R11", wave_out, 0);

    // R7: gate low forces output high and holds count
    gate_in = 1'b0;
    @(negedge clk);
    check(wave_out == 1'b1, "R7", wave_out, 1);
    step_tick();
    check(count_val == 16'd3, "R7", count_val, 3);

    // R8: gate rise reloads, output high, correction flip-flop cleared
    do_load(16'd5);
    gate_in = 1'b1;
    @(negedge clk);
    step_tick();
    check(count_val == 16'd5, "R8", count_val, 5);
    check(wave_out == 1'b1, "R8", wave_out, 1);
    step_tick();
    check(count_val == 16'd4, "R8", count_val, 4);

    // R6: mode set mid-run halts until the next load
    pulse_mode();
    check(wave_out == 1'b1, "R6", wave_out, 1);
    step_tick();
    check(count_val == 16'd4, "R6", count_val, 4);
    do_load(16'd9);
    step_tick();
    check(count_val == 16'd9, "R6", count_val, 9);

    // R10: zero means 65536
    pulse_mode();
    do_load(16'd0);
    step_tick();
    check(count_val == 16'd0, "R10", count_val, 0);
    check(wave_out == 1'b1, "R10", wave_out, 1);
    step_tick();
    check(count_val == 16'd65534, "R10", count_val, 65534);
    measure_run(32768, 32768, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule